// File: doc/BRIEF.md
# At-Speed Scan Clock Switch

This block feeds the clock of one clock domain during scan test. It chooses between three sources. When scan enable is high, the slow tester shift clock passes straight through so that the scan chains can be loaded and unloaded. When scan enable is low and the at-speed test flag is high, the output carries a burst of exactly `BURST_LEN` full pulses of the functional PLL clock. The first pulse launches a transition and the last one captures it. When both scan enable and the test flag are low, the functional clock passes through ungated, which is mission mode.

The burst gate is generated from the functional clock alone. A trigger flop and a chain of non-scan stages are all clocked on the falling edge of that clock, so the gate only changes while the clock is low. No pulse can therefore be clipped, and no timing relationship with the tester inputs is needed. The trigger stage costs one functional cycle, which gives scan enable time to settle at every scan flop before the launch pulse. Every stage is cleared asynchronously while scan enable is high, so each capture window starts clean. A per-switch capture enable selects which domains pulse in a given pattern.

The trigger is a two-state machine. IDLE moves to FIRED on a falling edge where the test flag and the capture enable are both high. FIRED holds until scan enable clears it back to IDLE. The output selector names three sources: SHIFT, BURST and MISSION.

Top module: `scan_clk_switch`

## Requirements
- R1: While `scan_en` is high, `clk_out` equals `clk_shift`. No functional clock edge appears on it.
- R2: The trigger fires only on a falling edge of `clk_pll` where `scan_en` is low and both `speed_mode` and `cap_en` are high. Once fired, it stays set until `scan_en` rises, even if `cap_en` later drops.
- R3: Raising `scan_en` clears the trigger and every window stage asynchronously. Each new capture window therefore yields a fresh burst, and at most one burst occurs per window.
- R4: The burst gate opens at the third falling edge of `clk_pll` after the trigger conditions first hold. The first burst pulse is the next rising edge of `clk_pll`.
- R5: The gate stays open for exactly `BURST_LEN` `clk_pll` periods, from one falling edge to another. It then stays closed until `scan_en` is raised again. With a window of L periods from `scan_en` falling to `scan_en` rising (both while `clk_pll` is low), the pulse count is min(max(L-3,0), `BURST_LEN`).
- R6: With `speed_mode` high and `scan_en` low, `clk_out` stays low as long as the trigger has not fired, for example when `cap_en` is low.
- R7: With `speed_mode` and `scan_en` both low, `clk_out` equals `clk_pll`: one pulse per period.
- R8: Every high phase on `clk_out` outside shift mode lasts a full half period of `clk_pll`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_pll | input | 1 | Functional clock from the PLL |
| clk_shift | input | 1 | Slow tester shift clock |
| scan_en | input | 1 | Scan shift enable, also clears the burst logic |
| speed_mode | input | 1 | At-speed test mode flag |
| cap_en | input | 1 | Capture enable for this switch |
| clk_out | output | 1 | Clock delivered to the domain |

## Verification
Two instances, with burst lengths of 2 and 4, are driven through capture windows of one to nine functional periods. The sweep covers every combination of the test flag and the capture enable. Short windows separate truncation from the full burst, and long windows show that the count saturates at the parameter. Further windows drop the capture enable after the trigger has fired, which separates a sticky trigger from a level-sensitive one. Raising the capture enable late shows that the burst start moves with the trigger. Timing the first pulse and the narrowest high phase exposes latency errors and clipped pulses. A shift phase with the PLL running shows that no functional edge leaks through.

// File: rtl/scw_pkg.sv
package scw_pkg;
    typedef enum logic [1:0] {
        SRC_SHIFT   = 2'd0,
        SRC_MISSION = 2'd1,
        SRC_BURST   = 2'd2
    } clk_src_e;

    typedef enum logic {
        TRG_IDLE  = 1'b0,
        TRG_FIRED = 1'b1
    } trg_state_e;
endpackage

// File: rtl/scw_trigger.sv
module scw_trigger
    import scw_pkg::*;
(
    input  logic clk_pll,
    input  logic scan_en,
    input  logic speed_mode,
    input  logic cap_en,
    output logic trig
);
    trg_state_e state_q;
    trg_state_e state_nx;

    // State register: falling edge, cleared while shifting.
    always_ff @(negedge clk_pll or posedge scan_en) begin
        if (scan_en) state_q <= TRG_IDLE;
        else         state_q <= state_nx;
    end

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            TRG_IDLE:  if (speed_mode && cap_en) state_nx = TRG_FIRED;
            TRG_FIRED: state_nx = TRG_FIRED;
            default:   state_nx = TRG_IDLE;
        endcase
    end

    // Output process.
    always_comb begin
        trig = (state_q == TRG_FIRED);
    end
endmodule

// File: rtl/scw_window.sv
module scw_window #(
    parameter int BURST_LEN = 2
) (
    input  logic clk_pll,
    input  logic scan_en,
    input  logic trig,
    output logic win
);
    localparam int DEPTH = BURST_LEN + 2;

    logic [DEPTH-1:0] stg_q;

    // Stage chain on the falling edge; the first two form the synchronizer.
    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_stage
            if (i == 0) begin : g_head
                always_ff @(negedge clk_pll or posedge scan_en) begin
                    if (scan_en) stg_q[i] <= 1'b0;
                    else         stg_q[i] <= trig;
                end
            end else begin : g_tail
                always_ff @(negedge clk_pll or posedge scan_en) begin
                    if (scan_en) stg_q[i] <= 1'b0;
                    else         stg_q[i] <= stg_q[i-1];
                end
            end
        end
    endgenerate

    // Open from synchronizer output until the stage BURST_LEN further on.
    always_comb begin
        win = stg_q[1] & ~stg_q[DEPTH-1];
    end
endmodule

// File: rtl/scw_clk_select.sv
module scw_clk_select
    import scw_pkg::*;
(
    input  logic clk_pll,
    input  logic clk_shift,
    input  logic scan_en,
    input  logic speed_mode,
    input  logic win,
    output logic clk_out
);
    clk_src_e src;

    always_comb begin
        if (scan_en)         src = SRC_SHIFT;
        else if (speed_mode) src = SRC_BURST;
        else                 src = SRC_MISSION;
    end

    always_comb begin
        unique case (src)
            SRC_SHIFT:   clk_out = clk_shift;
            SRC_BURST:   clk_out = clk_pll & win;
            SRC_MISSION: clk_out = clk_pll;
            default:     clk_out = clk_pll;
        endcase
    end
endmodule

// File: rtl/scan_clk_switch.sv
module scan_clk_switch #(
    parameter int BURST_LEN = 2
) (
    input  logic clk_pll,
    input  logic clk_shift,
    input  logic scan_en,
    input  logic speed_mode,
    input  logic cap_en,
    output logic clk_out
);
    logic trig_q;
    logic burst_win;

    scw_trigger u_trigger (
        .clk_pll    (clk_pll),
        .scan_en    (scan_en),
        .speed_mode (speed_mode),
        .cap_en     (cap_en),
        .trig       (trig_q)
    );

    scw_window #(.BURST_LEN(BURST_LEN)) u_window (
        .clk_pll (clk_pll),
        .scan_en (scan_en),
        .trig    (trig_q),
        .win     (burst_win)
    );

    scw_clk_select u_select (
        .clk_pll    (clk_pll),
        .clk_shift  (clk_shift),
        .scan_en    (scan_en),
        .speed_mode (speed_mode),
        .win        (burst_win),
        .clk_out    (clk_out)
    );
endmodule

// File: rtl/scan_clk_switch_chk.sv
module scan_clk_switch_chk #(
    parameter int BURST_LEN = 2
) (
    input logic clk_pll,
    input logic clk_shift,
    input logic scan_en,
    input logic speed_mode,
    input logic cap_en,
    input logic clk_out,
    input logic trig,
    input logic win
);
    localparam int CW = $clog2(BURST_LEN + 2) + 1;

    logic [CW-1:0] open_cnt;

    always_ff @(negedge clk_pll or posedge scan_en) begin
        if (scan_en)  open_cnt <= '0;
        else if (win) open_cnt <= open_cnt + 1'b1;
    end

    assert_shift_follow_R1: assert property (@(posedge clk_pll) disable iff (!scan_en)
        clk_out == clk_shift);

    assert_trig_sticky_R2: assert property (@(negedge clk_pll) disable iff (scan_en)
        trig |=> trig);

    assert_trig_cause_R2: assert property (@(negedge clk_pll) disable iff (scan_en)
        $rose(trig) |-> $past(speed_mode && cap_en));

    assert_single_burst_R3: assert property (@(negedge clk_pll) disable iff (scan_en)
        $rose(win) |-> (open_cnt == '0));

    assert_burst_len_R5: assert property (@(negedge clk_pll) disable iff (scan_en)
        $fell(win) |-> (open_cnt == CW'(BURST_LEN)));

    assert_no_overrun_R5: assert property (@(negedge clk_pll) disable iff (scan_en)
        open_cnt <= CW'(BURST_LEN));

    assert_gate_idle_R6: assert property (@(negedge clk_pll) disable iff (scan_en)
        (speed_mode && !trig) |-> !win);

    assert_mission_pass_R7: assert property (@(negedge clk_pll) disable iff (scan_en)
        !speed_mode |-> clk_out);
endmodule

bind scan_clk_switch scan_clk_switch_chk #(.BURST_LEN(BURST_LEN)) u_chk (
    .clk_pll    (clk_pll),
    .clk_shift  (clk_shift),
    .scan_en    (scan_en),
    .speed_mode (speed_mode),
    .cap_en     (cap_en),
    .clk_out    (clk_out),
    .trig       (trig_q),
    .win        (burst_win)
);

// File: tb/scan_clk_switch_test.sv
`timescale 1ns/1ps
module scan_clk_switch_test;
    localparam int PER  = 20;
    localparam int HALF = PER / 2;
    localparam int QTR  = PER / 4;
    localparam int NA   = 2;
    localparam int NB   = 4;

    logic clk_pll = 1'b0;
    logic clk_shift = 1'b0;
    logic scan_en = 1'b1;
    logic speed_mode = 1'b0;
    logic cap_en = 1'b0;
    logic out_a;
    logic out_b;

    int total = 0;
    int bad = 0;

    bit counting = 1'b0;
    int cnt_a, cnt_b;
    realtime first_a, first_b, rise_a, rise_b, minw_a, minw_b, t_drop;

    scan_clk_switch #(.BURST_LEN(NA)) uut (
        .clk_pll(clk_pll), .clk_shift(clk_shift), .scan_en(scan_en),
        .speed_mode(speed_mode), .cap_en(cap_en), .clk_out(out_a));

    scan_clk_switch #(.BURST_LEN(NB)) uut_long (
        .clk_pll(clk_pll), .clk_shift(clk_shift), .scan_en(scan_en),
        .speed_mode(speed_mode), .cap_en(cap_en), .clk_out(out_b));

    always #(HALF) clk_pll = ~clk_pll;

    always @(posedge out_a) if (counting) begin
        if (cnt_a == 0) first_a = $realtime;
        cnt_a++; rise_a = $realtime;
    end
    always @(negedge out_a) if (counting && cnt_a > 0)
        if ($realtime - rise_a < minw_a) minw_a = $realtime - rise_a;
    always @(posedge out_b) if (counting) begin
        if (cnt_b == 0) first_b = $realtime;
        cnt_b++; rise_b = $realtime;
    end
    always @(negedge out_b) if (counting && cnt_b > 0)
        if ($realtime - rise_b < minw_b) minw_b = $realtime - rise_b;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int expect_cnt(input bit spd, input bit cap0, input int flip, input int len, input int n);
        int v;
        if (!spd) return len;
        if (cap0) v = len - 3;
        else if (flip > 0) v = len - 3 - flip;
        else return 0;
        if (v < 0) v = 0;
        if (v > n) v = n;
        return v;
    endfunction

    task automatic start_count();
        cnt_a = 0; cnt_b = 0;
        minw_a = 1.0e9; minw_b = 1.0e9;
        counting = 1'b1;
    endtask

    // Capture window of len functional periods; cap_en toggles after flip edges.
    task automatic run_window(input bit spd, input bit cap0, input int flip, input int len);
        int ea, eb, lat;
        @(negedge clk_pll); #(QTR);
        speed_mode = spd; cap_en = cap0;
        start_count();
        t_drop = $realtime;
        scan_en = 1'b0;
        for (int i = 1; i <= len; i++) begin
            @(negedge clk_pll); #(QTR);
            if (i == flip) cap_en = ~cap_en;
        end
        scan_en = 1'b1;
        #1;
        counting = 1'b0;
        ea = expect_cnt(spd, cap0, flip, len, NA);
        eb = expect_cnt(spd, cap0, flip, len, NB);
        // R5 / R6 / R7: pulse counts per window
        check(cnt_a == ea, spd ? (cap0 || flip > 0 ? "R5 burst count N=2" : "R6 idle gate N=2") : "R7 mission N=2", cnt_a, ea);
        check(cnt_b == eb, spd ? (cap0 || flip > 0 ? "R5 burst count N=4" : "R6 idle gate N=4") : "R7 mission N=4", cnt_b, eb);
        // R8: no narrow high phase
        if (cnt_a > 0) check(minw_a >= HALF, "R8 width N=2", int'(minw_a), HALF);
        if (cnt_b > 0) check(minw_b >= HALF, "R8 width N=4", int'(minw_b), HALF);
        // R4: launch pulse latency
        if (spd && ea > 0) begin
            lat = 3 * PER + HALF - QTR + ((!cap0) ? flip * PER : 0);
            check(int'(first_a - t_drop) == lat, "R4 launch latency N=2", int'(first_a - t_drop), lat);
            check(int'(first_b - t_drop) == lat, "R4 launch latency N=4", int'(first_b - t_drop), lat);
        end
    endtask

    initial begin
        #1;
        // reset state: shifting, clock follows low shift clock
        check(out_a == 1'b0 && out_b == 1'b0, "R1 reset state", out_a, 0);

        // R1: shift mode with PLL running
        @(negedge clk_pll); #(QTR);
        start_count();
        for (int i = 0; i < 5; i++) begin
            clk_shift = 1'b1; #(2 * PER);
            clk_shift = 1'b0; #(2 * PER);
        end
        counting = 1'b0;
        check(cnt_a == 5, "R1 shift edges N=2", cnt_a, 5);
        check(cnt_b == 5, "R1 shift edges N=4", cnt_b, 5);
        check(int'(minw_a) == 2 * PER, "R1 shift width", int'(minw_a), 2 * PER);

        // sweep: mode, capture enable, window length (R3 via repeated windows)
        for (int s = 0; s < 2; s++)
            for (int c = 0; c < 2; c++)
                for (int len = 1; len <= 9; len++)
                    run_window(s[0], c[0], 0, len);

        // R2: capture enable dropped after trigger fired -> burst unchanged
        run_window(1'b1, 1'b1, 1, 10);
        run_window(1'b1, 1'b1, 2, 10);
        // R2: capture enable raised late -> burst shifts
        run_window(1'b1, 1'b0, 2, 12);
        run_window(1'b1, 1'b0, 4, 8);
        // R3: back-to-back full windows each burst again
        run_window(1'b1, 1'b1, 0, 10);
        run_window(1'b1, 1'b1, 0, 10);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(PER * 150000);
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule